// File: doc/BRIEF.md
# Packed Register Access Command Engine

This engine sits on the controller side of a command mailbox. It executes one power-control register access command at a time. When `start` is pulsed, it captures the message byte, the sub-command id, the size field and a 16-byte write buffer. It then checks that the combination is legal and unpacks up to five 16-bit register addresses from the buffer, together with their data bytes where the sub-command carries them.

The engine has three sub-commands:
- a batch of byte writes;
- a batch of byte reads;
- a masked read-modify-write of a single register.

It carries out the accesses one by one over a byte-wide register-file request port that uses a valid/ready handshake. Read results are packed into a 16-byte read buffer. At the end it raises `done` for one cycle, with `err` and `err_code` describing the outcome.

The register-file port follows valid/ready rules with back-pressure:
- The engine raises `rf_req_valid` and keeps the request (`rf_req_we`, `rf_req_addr`, `rf_req_wdata`) unchanged until it sees `rf_req_ready` high at a clock edge. That edge is the transfer.
- For a read, the register file must present `rf_rdata` during the transfer cycle. `rf_rdata` is a combinational response to `rf_req_addr`.
- The register file may hold `rf_req_ready` low for any number of cycles.

Top module: `pwr_reg_cmd_engine`

## Requirements
- R1: A message byte other than 0xFF ends the command with `err`=1, `err_code`=1 and no register-file request. This check takes priority over R2 and R7.
- R2: Sub-command id 0 means write, 1 means read and 2 means read-modify-write. Any other id (3..15) ends the command with `err`=1, `err_code`=2 and no request. This check takes priority over R7.
- R3: Entry n's address is buffer byte 2n (low half) joined with byte 2n+1 (high half). Buffer byte k occupies `wbuf[8k+7:8k]`. Entries are accessed one at a time in ascending order.
- R4: A write needs size = 3 × count. Entry n is written with `rf_req_we`=1 and data from buffer byte 2·count+n.
- R5: A read needs size = 2 × count. Each request has `rf_req_we`=0. The byte returned for entry n lands in read-buffer byte n (`rbuf[8n+7:8n]`). All other read-buffer bytes read zero after any accepted command.
- R6: A read-modify-write needs size = 4. It takes its address from bytes 0–1, the value from byte 2 and the mask from byte 3. It reads the register, then always writes back (old & ~mask) | (value & mask).
- R7: A size that gives a count of 0, a count above 5, or no whole count for the id ends the command with `err`=1, `err_code`=3 and no request.
- R8: While `rf_req_valid` is high and `rf_req_ready` is low, the request stays valid with address, write-enable and write data unchanged. Each transfer is exactly one access.
- R9: `done` is high for exactly one cycle per command. For a legal command it comes in the cycle after the last transfer. For a rejected command it comes in the cycle after the start edge. `err`/`err_code` (code 0 on success) are valid with `done` and held until the next accepted start.
- R10: `start` is ignored while `busy` is high, as are changes on the command inputs after a start has been accepted.
- R11: After reset, `busy`, `done`, `err`, `err_code`, `rf_req_valid` and `rbuf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (sampled only when idle) |
| cmd_op | input | 8 | Message byte; 0xFF selects register access |
| cmd_id | input | 4 | Sub-command id |
| cmd_size | input | 8 | Size field of the command |
| wbuf | input | 128 | Write buffer, byte k at bits 8k+7:8k |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command failed |
| err_code | output | 8 | 0 ok, 1 bad message, 2 bad id, 3 bad size |
| rbuf | output | 128 | Read buffer, result n at byte n |
| rf_req_valid | output | 1 | Register-file request valid |
| rf_req_ready | input | 1 | Register file accepts request |
| rf_req_we | output | 1 | 1 write, 0 read |
| rf_req_addr | output | 16 | Register address |
| rf_req_wdata | output | 8 | Write data |
| rf_rdata | input | 8 | Read data, valid in the transfer cycle |

## Verification
If the start edge falls in cycle s, a rejected command shows `done` (with its error code) in cycle s+1, and a legal command presents its first request from cycle s+1. Each transfer at cycle t is followed either by the next request or, after the last one, by `done` at t+1. A read-modify-write adds its write request in the cycle after the read transfer.

The bench samples on the falling edge and logs each transfer with its cycle number. It then compares the exact cycle of `done` with the last logged transfer, or with the start cycle for a rejected command. This holds with `rf_req_ready` held high and also under a stall pattern that drops ready one cycle in three.

// File: rtl/prce_pkg.sv
package prce_pkg;
  localparam logic [7:0] OP_PWR = 8'hFF;

  localparam logic [7:0] ECODE_NONE = 8'd0;
  localparam logic [7:0] ECODE_OP   = 8'd1;
  localparam logic [7:0] ECODE_ID   = 8'd2;
  localparam logic [7:0] ECODE_SIZE = 8'd3;

  typedef enum logic [1:0] {
    K_WRITE = 2'd0,
    K_READ  = 2'd1,
    K_RMW   = 2'd2
  } kind_t;

  typedef enum logic [1:0] {
    S_IDLE, S_ACC, S_RMW_WR, S_FIN
  } state_t;
endpackage

// File: rtl/prce_cmd_check.sv
module prce_cmd_check
  import prce_pkg::*;
#(
  parameter int MAX_ENTRIES = 5,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input  logic [7:0]       op,
  input  logic [3:0]       id,
  input  logic [7:0]       size,
  output kind_t            kind,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       ecode
);
  localparam logic [7:0] MAXC = 8'(MAX_ENTRIES);

  logic [7:0] by3, by2;
  assign by3 = size / 8'd3;
  assign by2 = size >> 1;

  always_comb begin
    kind  = K_WRITE;
    count = '0;
    ecode = ECODE_NONE;
    if (op != OP_PWR) begin
      ecode = ECODE_OP;
    end else begin
      case (id)
        4'd0: begin
          kind = K_WRITE;
          if (size != 8'd0 && (size % 8'd3) == 8'd0 && by3 <= MAXC)
            count = CNT_W'(by3);
          else
            ecode = ECODE_SIZE;
        end
        4'd1: begin
          kind = K_READ;
          if (size != 8'd0 && !size[0] && by2 <= MAXC)
            count = CNT_W'(by2);
          else
            ecode = ECODE_SIZE;
        end
        4'd2: begin
          kind = K_RMW;
          if (size == 8'd4) count = CNT_W'(1);
          else              ecode = ECODE_SIZE;
        end
        default: ecode = ECODE_ID;
      endcase
    end
  end
endmodule

// File: rtl/prce_entry_select.sv
module prce_entry_select #(
  parameter int BUF_BYTES = 16,
  parameter int CNT_W     = 3,
  localparam int BI_W     = $clog2(BUF_BYTES)
) (
  input  logic [BUF_BYTES*8-1:0] buf_q,
  input  logic [CNT_W-1:0]       idx,
  input  logic [CNT_W-1:0]       count,
  output logic [15:0]            addr,
  output logic [7:0]             data,
  output logic [7:0]             mask
);
  logic [7:0] bytes [BUF_BYTES];

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_unpack
    assign bytes[g] = buf_q[8*g +: 8];
  end

  logic [BI_W-1:0] lo_i, hi_i, dat_i;
  assign lo_i  = BI_W'({idx, 1'b0});
  assign hi_i  = lo_i + BI_W'(1);
  assign dat_i = BI_W'({count, 1'b0}) + BI_W'(idx);

  assign addr = {bytes[hi_i], bytes[lo_i]};
  assign data = bytes[dat_i];
  assign mask = bytes[3];
endmodule

// File: rtl/pwr_reg_cmd_engine.sv
module pwr_reg_cmd_engine
  import prce_pkg::*;
#(
  parameter int MAX_ENTRIES = 5,
  parameter int BUF_BYTES   = 16,
  localparam int CNT_W      = $clog2(MAX_ENTRIES + 1),
  localparam int BUF_W      = BUF_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       cmd_op,
  input  logic [3:0]       cmd_id,
  input  logic [7:0]       cmd_size,
  input  logic [BUF_W-1:0] wbuf,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [7:0]       err_code,
  output logic [BUF_W-1:0] rbuf,
  output logic             rf_req_valid,
  input  logic             rf_req_ready,
  output logic             rf_req_we,
  output logic [15:0]      rf_req_addr,
  output logic [7:0]       rf_req_wdata,
  input  logic [7:0]       rf_rdata
);
  state_t           state;
  kind_t            kind_q, dkind;
  logic [CNT_W-1:0] count_q, idx_q, dcount;
  logic [7:0]       dcode, ecode_q, old_q;
  logic             err_q;
  logic [BUF_W-1:0] wbuf_q, rbuf_q;
  logic [15:0]      sel_addr;
  logic [7:0]       sel_data, sel_mask, merged;

  prce_cmd_check #(.MAX_ENTRIES(MAX_ENTRIES)) u_check (
    .op(cmd_op), .id(cmd_id), .size(cmd_size),
    .kind(dkind), .count(dcount), .ecode(dcode)
  );

  prce_entry_select #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_sel (
    .buf_q(wbuf_q), .idx(idx_q), .count(count_q),
    .addr(sel_addr), .data(sel_data), .mask(sel_mask)
  );

  assign merged = (old_q & ~sel_mask) | (sel_data & sel_mask);

  logic last_entry;
  assign last_entry = (idx_q == count_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      kind_q  <= K_WRITE;
      count_q <= '0;
      idx_q   <= '0;
      ecode_q <= ECODE_NONE;
      err_q   <= 1'b0;
      old_q   <= '0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          wbuf_q  <= wbuf;
          kind_q  <= dkind;
          count_q <= dcount;
          idx_q   <= '0;
          rbuf_q  <= '0;
          ecode_q <= dcode;
          err_q   <= (dcode != ECODE_NONE);
          state   <= (dcode != ECODE_NONE) ? S_FIN : S_ACC;
        end
        S_ACC: if (rf_req_ready) begin
          if (kind_q == K_READ) rbuf_q[{idx_q, 3'b000} +: 8] <= rf_rdata;
          if (kind_q == K_RMW) begin
            old_q <= rf_rdata;
            state <= S_RMW_WR;
          end else if (last_entry) begin
            state <= S_FIN;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        S_RMW_WR: if (rf_req_ready) state <= S_FIN;
        S_FIN:    state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rf_req_valid = (state == S_ACC) || (state == S_RMW_WR);
    rf_req_we    = (state == S_RMW_WR) || (kind_q == K_WRITE);
    rf_req_addr  = sel_addr;
    rf_req_wdata = (state == S_RMW_WR) ? merged : sel_data;
  end

  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);
  assign err      = err_q;
  assign err_code = ecode_q;
  assign rbuf     = rbuf_q;

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req_valid && !rf_req_ready |=> rf_req_valid && $stable(rf_req_addr)
      && $stable(rf_req_we) && $stable(rf_req_wdata));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_access_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && err |-> !rf_req_valid);

  assert_busy_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_rmw_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req_valid && rf_req_ready && !rf_req_we && kind_q == K_RMW
      |=> rf_req_valid && rf_req_we && $stable(rf_req_addr));
endmodule

// File: tb/tb_pwr_reg_cmd_engine.sv
module tb_pwr_reg_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MAXE = 5;
  localparam int BUFB = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] cmd_op = 0, cmd_size = 0;
  logic [3:0] cmd_id = 0;
  logic [127:0] wbuf = 0;
  logic busy, done, err;
  logic [7:0] err_code;
  logic [127:0] rbuf;
  logic rf_req_valid, rf_req_we;
  logic rf_req_ready = 1;
  logic [15:0] rf_req_addr;
  logic [7:0] rf_req_wdata, rf_rdata;

  pwr_reg_cmd_engine dut (.*);

  function automatic logic [7:0] rd_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign rf_rdata = rd_fn(rf_req_addr);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  bit stall_mode = 0;
  int log_n, done_n, done_cyc, last_hs;
  logic [15:0] log_addr [16];
  logic        log_we   [16];
  logic [7:0]  log_wd   [16];
  logic        d_err;
  logic [7:0]  d_code;
  logic [127:0] d_rbuf;

  always @(negedge clk) begin
    rf_req_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
    if (rst_n) begin
      if (rf_req_valid && rf_req_ready) begin
        if (log_n < 16) begin
          log_addr[log_n] = rf_req_addr;
          log_we[log_n]   = rf_req_we;
          log_wd[log_n]   = rf_req_wdata;
        end
        log_n++;
        last_hs = cyc;
      end
      if (done) begin
        done_n++;
        done_cyc = cyc;
        d_err = err; d_code = err_code; d_rbuf = rbuf;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [7:0] op, input logic [3:0] id, input logic [7:0] sz);
    if (op != 8'hFF) return 1;
    case (id)
      4'd0: return (sz != 0 && sz % 3 == 0 && sz / 3 <= MAXE) ? 0 : 3;
      4'd1: return (sz != 0 && sz % 2 == 0 && sz / 2 <= MAXE) ? 0 : 3;
      4'd2: return (sz == 4) ? 0 : 3;
      default: return 2;
    endcase
  endfunction

  task automatic run_cmd(input logic [7:0] op, input logic [3:0] id, input logic [7:0] sz,
                         input logic [127:0] wb, input bit interfere);
    int s_cyc, code, cnt, e_n, w;
    logic [15:0] e_addr [16];
    logic        e_we   [16];
    logic [7:0]  e_wd   [16];
    logic [127:0] e_rbuf;
    logic [15:0] a;
    log_n = 0; done_n = 0; done_cyc = -1; last_hs = -1;
    @(negedge clk); #1;
    cmd_op = op; cmd_id = id; cmd_size = sz; wbuf = wb; start = 1; s_cyc = cyc;
    @(negedge clk); #1;
    start = 0;
    if (interfere) begin
      @(negedge clk); #1;
      cmd_op = 8'hFF; cmd_id = 4'd1; cmd_size = 8'd2; wbuf = ~wb; start = 1;
      @(negedge clk); #1;
      start = 0;
    end
    w = 0;
    while (done_n == 0 && w < 300) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    code = exp_code(op, id, sz);
    chk(done_n == 1, "R9 one done pulse", 128'(done_n), 128'd1);
    chk(d_code == 8'(code) && d_err == (code != 0), "R1/R2/R7 error code",
        128'(d_code), 128'(code));
    e_n = 0; e_rbuf = '0;
    if (code != 0) begin
      chk(log_n == 0, "R7 no access on rejected command", 128'(log_n), 128'd0);
      chk(done_cyc == s_cyc + 1, "R9 rejected done timing", 128'(done_cyc), 128'(s_cyc + 1));
    end else begin
      cnt = (id == 0) ? sz / 3 : (id == 1) ? sz / 2 : 1;
      for (int n = 0; n < cnt; n++) begin
        a = {wb[8*(2*n+1) +: 8], wb[8*(2*n) +: 8]};
        e_addr[e_n] = a;
        if (id == 0) begin
          e_we[e_n] = 1; e_wd[e_n] = wb[8*(2*cnt+n) +: 8]; e_n++;
        end else if (id == 1) begin
          e_we[e_n] = 0; e_wd[e_n] = 0; e_n++;
          e_rbuf[8*n +: 8] = rd_fn(a);
        end else begin
          e_we[e_n] = 0; e_wd[e_n] = 0; e_n++;
          e_addr[e_n] = a; e_we[e_n] = 1;
          e_wd[e_n] = (rd_fn(a) & ~wb[31:24]) | (wb[23:16] & wb[31:24]); e_n++;
        end
      end
      chk(log_n == e_n, "R3 access count", 128'(log_n), 128'(e_n));
      for (int k = 0; k < e_n && k < log_n; k++) begin
        chk(log_addr[k] == e_addr[k], "R3 address unpack/order", 128'(log_addr[k]), 128'(e_addr[k]));
        chk(log_we[k] == e_we[k], "R4/R5/R6 access direction", 128'(log_we[k]), 128'(e_we[k]));
        if (e_we[k])
          chk(log_wd[k] == e_wd[k], (id == 2) ? "R6 masked merge data" : "R4 write data",
              128'(log_wd[k]), 128'(e_wd[k]));
      end
      chk(done_cyc == last_hs + 1, "R9 done after last transfer", 128'(done_cyc), 128'(last_hs + 1));
    end
    chk(d_rbuf == e_rbuf, "R5 read buffer packing", d_rbuf, e_rbuf);
  endtask

  initial begin
    log_n = 0; done_n = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && err_code == 0 && !rf_req_valid && rbuf == 0,
        "R11 reset state", {busy, done, err, rf_req_valid, err_code}, 128'd0);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!busy && !rf_req_valid, "R11 idle after reset", {busy, rf_req_valid}, 128'd0);
    for (int rm = 0; rm < 2; rm++) begin
      stall_mode = (rm == 1);
      for (int id = 0; id < 4; id++)
        for (int sz = 0; sz < 18; sz++) begin
          logic [127:0] wb;
          for (int b = 0; b < BUFB; b++) wb[8*b +: 8] = 8'(b * 37 + sz * 11 + id * 5 + rm * 3 + 1);
          run_cmd(8'hFF, 4'(id), 8'(sz), wb, 1'b0);
        end
    end
    run_cmd(8'h00, 4'd1, 8'd2, 128'h0123_4567_89AB_CDEF_1122_3344_5566_7788, 1'b0); // R1
    run_cmd(8'hFE, 4'd0, 8'd3, 128'hA5A5_5A5A_0F0F_F0F0_1357_9BDF_2468_ACE0, 1'b0); // R1
    run_cmd(8'hFF, 4'd15, 8'd2, 128'h1, 1'b0); // R2
    run_cmd(8'hFF, 4'd2, 8'd4, 128'h0000_0000_0000_0000_0000_0000_FF00_1234, 1'b0); // R6 full mask
    run_cmd(8'hFF, 4'd2, 8'd4, 128'h0000_0000_0000_0000_0000_0000_00FF_1234, 1'b0); // R6 zero mask
    stall_mode = 1;
    run_cmd(8'hFF, 4'd0, 8'd15, 128'hFEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978, 1'b1); // R10
    stall_mode = 0;
    run_cmd(8'hFF, 4'd1, 8'd10, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 1'b1); // R10
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule